// File: doc/BRIEF.md
# Three-Window Segment Approximate Multiplier

This block multiplies two unsigned 16-bit operands approximately. It uses a single 8×8 multiplier core instead of a full 16×16 array. From each operand it takes one 8-bit slice out of three fixed, overlapping windows. The upper window covers bits 15..8, the middle window covers bits 11..4 and the lower window covers bits 7..0. The windows are four bits apart, so the slice can follow the operand's most significant set bit much more closely than with two windows. No leading-one detector or barrel shifter is needed.

Each operand picks its window by priority, using the OR of its two upper nibbles. The two 8-bit slices are multiplied. The 16-bit core product is then shifted left by the sum of the two window offsets, and a 5-way alignment multiplexer places it in the 32-bit result. Bits that fall below the chosen window are dropped, so the result never exceeds the true product. The result is exact whenever both operands fit in eight bits.

The block is purely combinational. It suits filter and classification datapaths that can tolerate a small relative error in exchange for a much smaller multiplier.

Top module: `seg3_approx_mul`

## Requirements
- R1: When an operand has any of bits [15:12] set, its slice is bits [15:8] with a window offset of 8.
- R2: When an operand has bits [15:12] all zero and any of bits [11:8] set, its slice is bits [11:4] with a window offset of 4.
- R3: When an operand has bits [15:8] all zero, its slice is bits [7:0] with a window offset of 0.
- R4: When both operands are below 256, the result equals the exact product.
- R5: The result never exceeds the exact 32-bit product of the two operands.
- R6: If either operand is zero, the result is zero.
- R7: The result equals the product of the two slices, shifted left by the sum of the two window offsets. That sum is one of 0, 4, 8, 12 or 16.
- R8: With both operands at 0xFFFF, the result is 0xFE010000.
- R9: The slice chosen for a nonzero operand always holds that operand's most significant set bit in its top nibble, unless the lower window was chosen.
- R10: The result depends only on the present operand values, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 16 | First unsigned operand |
| op_b_i | input | 16 | Second unsigned operand |
| prod_o | output | 32 | Approximate unsigned product |

## Verification
The directed patterns are chosen to separate the three window decisions:
- Operands of zero and all ones.
- Single set bits at bits 3, 4, 7, 8, 11, 12 and 15, which lie on both sides of every nibble boundary that moves the window.
- Small pairs below 256, which must come out exact, unlike the windowed pairs.

Random pairs are drawn with per-operand magnitude masks, so all nine window combinations and all five output offsets occur. A wrong priority order, a swapped slice or a wrong alignment offset each produces a mismatch against a bench model of the windowing rule. Every random result is also compared against the exact product, to confirm that it never exceeds it.

// File: rtl/seg3_pkg.sv
package seg3_pkg;

    // Window choice per operand; numeric value times the step gives the offset
    typedef enum logic [1:0] {
        WIN_LO  = 2'd0,
        WIN_MID = 2'd1,
        WIN_HI  = 2'd2
    } win_sel_e;

    localparam int NUM_WIN = 3;
    localparam int NUM_POS = 2 * NUM_WIN - 1;

endpackage

// File: rtl/seg3_window_sel.sv
module seg3_window_sel
    import seg3_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int SEG_W = 8
) (
    input  logic [OP_W-1:0]  op_i,
    output logic [SEG_W-1:0] seg_o,
    output win_sel_e         sel_o
);
    localparam int STEP = (OP_W - SEG_W) / 2;

    logic top_any;
    logic mid_any;

    assign top_any = |op_i[OP_W-1 -: STEP];
    assign mid_any = |op_i[OP_W-STEP-1 -: STEP];

    always_comb begin
        if (top_any)      sel_o = WIN_HI;
        else if (mid_any) sel_o = WIN_MID;
        else              sel_o = WIN_LO;
    end

    always_comb begin
        case (sel_o)
            WIN_HI:  seg_o = op_i[OP_W-1 -: SEG_W];
            WIN_MID: seg_o = op_i[OP_W-STEP-1 -: SEG_W];
            default: seg_o = op_i[SEG_W-1:0];
        endcase
    end

    always_comb begin
        if (!$isunknown(op_i)) begin
            // R3: lower window only when nothing above it is lost
            p_lo_no_loss_r3 : assert ((sel_o != WIN_LO) || (op_i[OP_W-1:SEG_W] == '0))
                else $error("lower window chosen with upper bits set");
            // R1: upper window only when top nibble is populated
            p_hi_needs_top_r1 : assert ((sel_o != WIN_HI) || (op_i[OP_W-1 -: STEP] != '0))
                else $error("upper window chosen with empty top nibble");
            // R9: leading one sits in the slice's top nibble for shifted windows
            p_lead_in_seg_r9 : assert ((sel_o == WIN_LO) || (seg_o[SEG_W-1 -: STEP] != '0))
                else $error("slice lost the leading one");
        end
    end

endmodule

// File: rtl/seg3_core_mul.sv
module seg3_core_mul #(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0]   a_i,
    input  logic [SEG_W-1:0]   b_i,
    output logic [2*SEG_W-1:0] p_o
);
    localparam int PROD_W = 2 * SEG_W;

    logic [PROD_W-1:0] acc [SEG_W+1];

    assign acc[0] = '0;

    for (genvar i = 0; i < SEG_W; i++) begin : g_row
        logic [PROD_W-1:0] pp;
        assign pp         = b_i[i] ? ({{SEG_W{1'b0}}, a_i} << i) : '0;
        assign acc[i + 1] = acc[i] + pp;
    end

    assign p_o = acc[SEG_W];

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            // R6: zero in, zero out; nonzero slices give nonzero product
            p_zero_iff_r6 : assert ((p_o == '0) == ((a_i == '0) || (b_i == '0)))
                else $error("core zero mismatch");
        end
    end

endmodule

// File: rtl/seg3_align.sv
module seg3_align
    import seg3_pkg::*;
#(
    parameter int SEG_W = 8,
    parameter int OP_W  = 16
) (
    input  logic [2*SEG_W-1:0] prod_i,
    input  logic [2:0]         pos_i,
    output logic [2*OP_W-1:0]  res_o
);
    localparam int PROD_W = 2 * SEG_W;
    localparam int RES_W  = 2 * OP_W;
    localparam int STEP   = (OP_W - SEG_W) / 2;

    logic [RES_W-1:0] cand [NUM_POS];

    for (genvar k = 0; k < NUM_POS; k++) begin : g_pos
        assign cand[k] = {{(RES_W-PROD_W){1'b0}}, prod_i} << (k * STEP);
    end

    always_comb begin
        res_o = '0;
        for (int k = 0; k < NUM_POS; k++) begin
            if (pos_i == 3'(k)) res_o = cand[k];
        end
    end

    always_comb begin
        if (!$isunknown(pos_i)) begin
            // R7: offset sum must be one of the five legal positions
            p_pos_range_r7 : assert (pos_i < 3'(NUM_POS))
                else $error("alignment position out of range");
        end
    end

endmodule

// File: rtl/seg3_approx_mul.sv
module seg3_approx_mul
    import seg3_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int SEG_W = 8
) (
    input  logic [OP_W-1:0]   op_a_i,
    input  logic [OP_W-1:0]   op_b_i,
    output logic [2*OP_W-1:0] prod_o
);
    localparam int PROD_W = 2 * SEG_W;
    localparam int RES_W  = 2 * OP_W;

    logic [SEG_W-1:0]  seg_a, seg_b;
    win_sel_e          sel_a, sel_b;
    logic [PROD_W-1:0] core_p;
    logic [2:0]        pos_sum;

    seg3_window_sel #(.OP_W(OP_W), .SEG_W(SEG_W)) u_sel_a (
        .op_i  (op_a_i),
        .seg_o (seg_a),
        .sel_o (sel_a)
    );

    seg3_window_sel #(.OP_W(OP_W), .SEG_W(SEG_W)) u_sel_b (
        .op_i  (op_b_i),
        .seg_o (seg_b),
        .sel_o (sel_b)
    );

    seg3_core_mul #(.SEG_W(SEG_W)) u_core (
        .a_i (seg_a),
        .b_i (seg_b),
        .p_o (core_p)
    );

    assign pos_sum = {1'b0, sel_a} + {1'b0, sel_b};

    seg3_align #(.SEG_W(SEG_W), .OP_W(OP_W)) u_align (
        .prod_i (core_p),
        .pos_i  (pos_sum),
        .res_o  (prod_o)
    );

    logic [RES_W-1:0] exact_p;
    assign exact_p = RES_W'(op_a_i) * RES_W'(op_b_i);

    always_comb begin
        if (!$isunknown({op_a_i, op_b_i})) begin
            // R5: never above the exact product
            p_no_overshoot_r5 : assert (prod_o <= exact_p)
                else $error("approximate product exceeds exact");
            // R4: small operands give the exact answer
            p_exact_small_r4 : assert ((op_a_i[OP_W-1:SEG_W] != '0) ||
                                       (op_b_i[OP_W-1:SEG_W] != '0) ||
                                       (prod_o == exact_p))
                else $error("small operands not exact");
        end
    end

endmodule

// File: tb/seg3_approx_mul_bench.sv
module seg3_approx_mul_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 100000;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0;
    logic [15:0] op_a, op_b;
    logic [31:0] prod;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg3_approx_mul u_seg3_approx_mul (
        .op_a_i (op_a),
        .op_b_i (op_b),
        .prod_o (prod)
    );

    function automatic int win_shift(input logic [15:0] x);
        if (x[15:12] != 4'd0)     return 8;
        else if (x[11:8] != 4'd0) return 4;
        else                      return 0;
    endfunction

    function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b);
        int sa = win_shift(a);
        int sb = win_shift(b);
        logic [7:0] ga = 8'(a >> sa);
        logic [7:0] gb = 8'(b >> sb);
        return (32'(ga) * 32'(gb)) << (sa + sb);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h got=%h exp=%h", tag, op_a, op_b, got, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        #(CLK_PERIOD/4);
    endtask

    task automatic run_pair(input logic [15:0] a, input logic [15:0] b);
        string wtag;
        int sa;
        logic [31:0] exact;
        apply(a, b);
        sa = win_shift(a);
        wtag = (sa == 8) ? "R1" : (sa == 4) ? "R2" : "R3";
        check({wtag, "/R7 windowed product"}, prod, model(a, b));
        exact = 32'(a) * 32'(b);
        checks++;
        if (prod > exact) begin
            failures++;
            $display("FAIL R5 a=%h b=%h got=%h exp<=%h", a, b, prod, exact);
        end
    endtask

    initial begin
        logic [15:0] masks [3];
        int unused_seed;
        masks[0] = 16'hFFFF; masks[1] = 16'h0FFF; masks[2] = 16'h00FF;
        unused_seed = $urandom(32'd52711);
        op_a = '0; op_b = '0;

        // R10: combinational result from initial operands, R6 zero case
        apply(16'h0000, 16'h0000);
        check("R6 R10 both zero", prod, 32'h0);
        apply(16'h0000, 16'hFFFF);
        check("R6 zero times all-ones", prod, 32'h0);
        apply(16'hBEEF, 16'h0000);
        check("R6 operand b zero", prod, 32'h0);
        apply(16'hFFFF, 16'hFFFF);
        check("R8 all ones", prod, 32'hFE010000);
        apply(16'h00FF, 16'h00FF);
        check("R4 max exact", prod, 32'h0000FE01);
        apply(16'h0007, 16'h0023);
        check("R4 small pair", prod, 32'd245);
        apply(16'h0100, 16'h0100);
        check("R2 bit8 both", prod, 32'h00010000);
        apply(16'h1000, 16'h0001);
        check("R1 bit12 by one", prod, 32'h00001000);
        apply(16'h8001, 16'h0003);
        check("R1 low bits dropped", prod, 32'h00018000);
        apply(16'h0F0F, 16'h0001);
        check("R2 low nibble dropped", prod, 32'h00000F00);
        // R10: change operand only, result follows at once
        apply(16'h0F0F, 16'h0002);
        check("R10 follows input", prod, 32'h00001E00);

        // single set bits at nibble boundaries, all pairings
        foreach (masks[i]) begin end
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                int bits [7] = '{3, 4, 7, 8, 11, 12, 15};
                run_pair(16'(1) << bits[i], 16'(1) << bits[j]);
            end
        end

        for (int n = 0; n < N_RAND; n++) begin
            logic [15:0] ra = 16'($urandom) & masks[$urandom % 3];
            logic [15:0] rb = 16'($urandom) & masks[$urandom % 3];
            run_pair(ra, rb);
            if (ra[15:8] == 8'd0 && rb[15:8] == 8'd0)
                check("R4 random small exact", prod, 32'(ra) * 32'(rb));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule